// File: doc/BRIEF.md
# Four-Stage Delayed-Branch Integer Core

This block is a small pipelined integer processor for a 16-bit register-to-register instruction set. An instruction moves through four stages: fetch, operand read, ALU with register write-back, and a memory stage that only loads and stores use. One instruction enters the pipeline each cycle, and no stage ever stalls. Instruction fetch and data access go through separate synchronous memory ports, so a fetch and a load or store can take place in the same cycle.

Branches and jumps are resolved in the operand-read stage, and they are delayed. The instruction that follows a branch in memory always executes, and the core has no logic to cancel work already in flight. ALU results are forwarded to the instruction that immediately follows. Load results are not forwarded, so software must place one unrelated instruction (or a NOOP) directly after a load whose result it needs.

Top module: `r4_core`

## Requirements
- R1: Outside a taken branch or jump, `imem_addr` advances by one every cycle. Instruction data that returns one cycle after an address is presented enters operand read in that cycle.
- R2: Instruction word layout: opcode in bits 15:12, destination/first register in bits 11:8, second source in bits 7:4, third source or 4-bit offset in bits 3:0. The 8-bit immediate is bits 7:0. Opcodes: 0 NOOP, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 ADDI, 6 LOAD, 7 STORE, 8 BEQ, 9 JUMP, F HALT. The values A to E behave as NOOP.
- R3: ADD, SUB, AND and OR write rd = rs op rt, with 16-bit wrap-around.
- R4: ADDI writes rd = rd + the sign-extended 8-bit immediate.
- R5: LOAD writes rd with memory[R[rs] + zero-extended bits 3:0]. The result can be used by the second instruction after the load, and `dmem_re` is followed one cycle later by the register write.
- R6: STORE drives `dmem_we`, the address R[rs] + zero-extended bits 3:0, and data R[rd] in the cycle two after its fetch address was presented. `dmem_we` and `dmem_re` are never high together.
- R7: An ALU or ADDI result is seen by the very next instruction, including a store's data and a branch compare.
- R8: BEQ (compares R[rd] and R[rs]) and JUMP have one delay slot: the next sequential instruction always executes. A taken BEQ goes to its own address + 1 + sign-extended bits 3:0. JUMP goes to the 8-bit immediate.
- R9: Register 0 always reads as zero, and writes to it are dropped.
- R10: While `rst_n` is low at a clock edge, the fetch address becomes 0, every stage becomes a NOOP and all registers are cleared. No store or halt appears in the cycle after a reset edge.
- R11: `halt` is high in the cycle in which an opcode-F instruction sits in the ALU stage, which is two cycles after its fetch address was presented.
- R12: NOOP changes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | IADDR_W | Fetch address (program counter) |
| imem_rdata | input | 16 | Instruction word, one cycle after its address |
| dmem_addr | output | DADDR_W | Data address for load or store |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_wdata | output | DATA_W | Store data |
| dmem_rdata | input | DATA_W | Load data, one cycle after the request |
| halt | output | 1 | Halt instruction is in the ALU stage |

## Verification
A corrupted program counter or a wrong branch decision shows on `imem_addr` in the very next cycle. A wrong register value, a lost forward or a missing load write-back stays hidden until a later store puts that register on `dmem_wdata`, or a branch that depends on it changes the fetch sequence. A wrong value therefore shows two cycles after the store that consumes it is fetched. The test programs store every computed register soon after it is produced and compare the fetch address, store strobe, address, data and `halt` every cycle, so each such fault shows within a few cycles of its cause.

// File: rtl/r4_pkg.sv
// Shared encodings for the four-stage core: opcodes, ALU functions and the
// decoded-instruction record passed from decode to the pipeline.
// Assumes a fixed 16-bit instruction with 4-bit opcode and register fields.
package r4_pkg;

    localparam int INSTR_W = 16;
    localparam int RFLD_W  = 4;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_ADD   = 4'h1,
        OP_SUB   = 4'h2,
        OP_AND   = 4'h3,
        OP_OR    = 4'h4,
        OP_ADDI  = 4'h5,
        OP_LOAD  = 4'h6,
        OP_STORE = 4'h7,
        OP_BEQ   = 4'h8,
        OP_JUMP  = 4'h9,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_OR} alu_fn_e;

    typedef enum logic [1:0] {SRCB_REG, SRCB_IMM8, SRCB_OFF4} srcb_e;

    typedef struct packed {
        alu_fn_e           fn;
        srcb_e             srcb;
        logic              wr_alu;
        logic              is_load;
        logic              is_store;
        logic              is_beq;
        logic              is_jump;
        logic              is_halt;
        logic [RFLD_W-1:0] ra;
        logic [RFLD_W-1:0] rb;
        logic [RFLD_W-1:0] rd;
        logic [7:0]        imm8;
    } dec_t;

endpackage

// File: rtl/r4_decode.sv
// Instruction decoder: turns the raw word in the operand-read stage into
// control flags and register addresses. Assumes `live` is low for the
// cycle after reset, when the fetch port holds no valid word yet.
module r4_decode
    import r4_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               live,
    output dec_t               dec
);

    logic [3:0] opc;
    assign opc = instr[15:12];

    // Map the opcode to flags and pick which fields feed the read ports.
    always_comb begin
        dec      = '0;
        dec.fn   = FN_ADD;
        dec.srcb = SRCB_REG;
        dec.rd   = instr[11:8];
        dec.ra   = instr[7:4];
        dec.rb   = instr[3:0];
        dec.imm8 = instr[7:0];
        if (live) begin
            case (opc)
                OP_ADD:   dec.wr_alu = 1'b1;
                OP_SUB:   begin dec.wr_alu = 1'b1; dec.fn = FN_SUB; end
                OP_AND:   begin dec.wr_alu = 1'b1; dec.fn = FN_AND; end
                OP_OR:    begin dec.wr_alu = 1'b1; dec.fn = FN_OR;  end
                OP_ADDI:  begin
                    dec.wr_alu = 1'b1;
                    dec.srcb   = SRCB_IMM8;
                    dec.ra     = instr[11:8];
                end
                OP_LOAD:  begin dec.is_load = 1'b1; dec.srcb = SRCB_OFF4; end
                OP_STORE: begin
                    dec.is_store = 1'b1;
                    dec.srcb     = SRCB_OFF4;
                    dec.rb       = instr[11:8];
                end
                OP_BEQ:   begin dec.is_beq = 1'b1; dec.rb = instr[11:8]; end
                OP_JUMP:  dec.is_jump = 1'b1;
                OP_HALT:  dec.is_halt = 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/r4_regfile.sv
// Register file with two read and two write ports. Port 0 takes ALU
// results (the younger instruction) and wins over port 1 (load returns).
// Reads see a same-cycle write, which forms the ALU forwarding path.
// Entry 0 is a constant zero.
module r4_regfile #(
    parameter  int DATA_W = 16,
    parameter  int NREG   = 16,
    localparam int AW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra_a,
    input  logic [AW-1:0]     ra_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    input  logic              w0_en,
    input  logic [AW-1:0]     w0_addr,
    input  logic [DATA_W-1:0] w0_data,
    input  logic              w1_en,
    input  logic [AW-1:0]     w1_addr,
    input  logic [DATA_W-1:0] w1_data
);

    logic [DATA_W-1:0] q [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            if (i == 0) begin : g_zero
                assign q[i] = '0;
            end else begin : g_live
                // Hold one register; port 0 has priority on a collision.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q[i] <= '0;
                    else if (w0_en && w0_addr == AW'(i))
                        q[i] <= w0_data;
                    else if (w1_en && w1_addr == AW'(i))
                        q[i] <= w1_data;
                end
            end
        end
    endgenerate

    function automatic logic [DATA_W-1:0] read_port(input logic [AW-1:0] a);
        if (a == '0)                  return '0;
        if (w0_en && w0_addr == a)    return w0_data;
        if (w1_en && w1_addr == a)    return w1_data;
        return q[a];
    endfunction

    // Serve both read ports with write-through.
    always_comb begin
        rdata_a = read_port(ra_a);
        rdata_b = read_port(ra_b);
    end

endmodule

// File: rtl/r4_alu.sv
// Combinational ALU for the ALU stage: add, subtract, and, or.
// Assumes results wrap at DATA_W bits.
module r4_alu
    import r4_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    // Select the operation.
    always_comb begin
        case (fn)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/r4_core.sv
// Four-stage integer core: fetch, operand read (with branch resolution),
// ALU plus write-back, and a memory stage for load returns. Branches have
// one delay slot and nothing is ever squashed. Assumes synchronous
// instruction and data memories with one cycle of read latency.
module r4_core
    import r4_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int IADDR_W = 8,
    parameter int DADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IADDR_W-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_we,
    output logic               dmem_re,
    output logic [DATA_W-1:0]  dmem_wdata,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic               halt
);

    localparam int NREG = 1 << RFLD_W;
    localparam logic [IADDR_W-1:0] PC_ONE = IADDR_W'(1);

    // fetch / operand-read state
    logic [IADDR_W-1:0] pc_q, e1_pc_q, pc_next, br_tgt;
    logic               e1_live_q, take;
    dec_t               dec;
    logic [DATA_W-1:0]  opa, opb, src_b;

    // ALU-stage state
    alu_fn_e            e2_fn_q;
    logic               e2_wr_q, e2_load_q, e2_store_q, e2_halt_q;
    logic [RFLD_W-1:0]  e2_rd_q;
    logic [DATA_W-1:0]  e2_a_q, e2_b_q, e2_sdata_q, alu_y;

    // memory-stage state
    logic               m_load_q;
    logic [RFLD_W-1:0]  m_rd_q;

    r4_decode u_dec (
        .instr (imem_rdata),
        .live  (e1_live_q),
        .dec   (dec)
    );

    r4_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_a    (dec.ra),
        .ra_b    (dec.rb),
        .rdata_a (opa),
        .rdata_b (opb),
        .w0_en   (e2_wr_q),
        .w0_addr (e2_rd_q),
        .w0_data (alu_y),
        .w1_en   (m_load_q),
        .w1_addr (m_rd_q),
        .w1_data (dmem_rdata)
    );

    // Resolve the branch in operand read and choose the next fetch address.
    always_comb begin
        take   = dec.is_jump || (dec.is_beq && (opa == opb));
        br_tgt = dec.is_jump ? IADDR_W'(dec.imm8)
                             : e1_pc_q + PC_ONE
                               + {{(IADDR_W-4){dec.imm8[3]}}, dec.imm8[3:0]};
        pc_next = take ? br_tgt : pc_q + PC_ONE;
    end

    // Advance the program counter and track the word in operand read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            e1_pc_q   <= '0;
            e1_live_q <= 1'b0;
        end else begin
            pc_q      <= pc_next;
            e1_pc_q   <= pc_q;
            e1_live_q <= 1'b1;
        end
    end

    // Choose the second ALU operand from the decoded source kind.
    always_comb begin
        case (dec.srcb)
            SRCB_IMM8: src_b = {{(DATA_W-8){dec.imm8[7]}}, dec.imm8};
            SRCB_OFF4: src_b = DATA_W'(dec.imm8[3:0]);
            default:   src_b = opb;
        endcase
    end

    // Register operand read into the ALU stage; reset loads a NOOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e2_fn_q    <= FN_ADD;
            e2_wr_q    <= 1'b0;
            e2_load_q  <= 1'b0;
            e2_store_q <= 1'b0;
            e2_halt_q  <= 1'b0;
            e2_rd_q    <= '0;
            e2_a_q     <= '0;
            e2_b_q     <= '0;
            e2_sdata_q <= '0;
        end else begin
            e2_fn_q    <= dec.fn;
            e2_wr_q    <= dec.wr_alu;
            e2_load_q  <= dec.is_load;
            e2_store_q <= dec.is_store;
            e2_halt_q  <= dec.is_halt;
            e2_rd_q    <= dec.rd;
            e2_a_q     <= opa;
            e2_b_q     <= src_b;
            e2_sdata_q <= opb;
        end
    end

    r4_alu #(.DATA_W(DATA_W)) u_alu (
        .fn (e2_fn_q),
        .a  (e2_a_q),
        .b  (e2_b_q),
        .y  (alu_y)
    );

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y[DADDR_W-1:0];
    assign dmem_we    = e2_store_q;
    assign dmem_re    = e2_load_q;
    assign dmem_wdata = e2_sdata_q;
    assign halt       = e2_halt_q;

    // Carry a pending load into the memory stage for its write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_load_q <= 1'b0;
            m_rd_q   <= '0;
        end else begin
            m_load_q <= e2_load_q;
            m_rd_q   <= e2_rd_q;
        end
    end

endmodule

// File: rtl/r4_core_chk.sv
// Property checker for r4_core, attached by bind. Watches fetch order,
// reset state, memory strobes, stage hand-off and the zero register.
module r4_core_chk #(
    parameter int IADDR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IADDR_W-1:0] imem_addr,
    input logic               dmem_we,
    input logic               dmem_re,
    input logic               halt,
    input logic               e1_ctl,
    input logic               e1_halt,
    input logic [3:0]         rf_ra_a,
    input logic [15:0]        rf_rdata_a,
    input logic               m_load
);

    localparam logic [IADDR_W-1:0] STEP = IADDR_W'(1);

    AST_RESET_PC_ZERO: assert property (@(posedge clk)
        !rst_n |=> imem_addr == '0);  // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!dmem_we && !halt));  // R10

    AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !e1_ctl) |=> imem_addr == ($past(imem_addr) + STEP));  // R1

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));  // R6

    AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && e1_halt) |=> halt);  // R11

    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && dmem_re) |=> m_load);  // R5

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        rf_ra_a == 4'd0 |-> rf_rdata_a == 16'd0);  // R9

endmodule

bind r4_core r4_core_chk #(.IADDR_W(IADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .halt       (halt),
    .e1_ctl     (dec.is_beq || dec.is_jump),
    .e1_halt    (dec.is_halt),
    .rf_ra_a    (dec.ra),
    .rf_rdata_a (opa),
    .m_load     (m_load_q)
);

// File: tb/test_r4_core.sv
// Bench: an instruction-level reference model with delayed-branch order
// predicts, per cycle, the fetch address, store activity and halt.
module test_r4_core;

    localparam int MAXC = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [15:0] imem_rdata;
    logic [7:0]  dmem_addr;
    logic        dmem_we, dmem_re;
    logic [15:0] dmem_wdata, dmem_rdata;
    logic        halt;

    logic [15:0] imem [256];
    logic [15:0] dmem [256];
    string       tag_of [256];

    int          exp_pc   [MAXC];
    bit          exp_we   [MAXC];
    int          exp_addr [MAXC];
    logic [15:0] exp_wd   [MAXC];
    bit          exp_halt [MAXC];
    string       exp_tag  [MAXC];
    int          last_cyc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    r4_core i_r4_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_re(dmem_re),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .halt(halt)
    );

    // synchronous memories
    always @(posedge clk) imem_rdata <= imem[imem_addr];
    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr];
    end

    // R2: field layout op[15:12] rd[11:8] rs[7:4] rt/off[3:0], imm[7:0]
    function automatic logic [15:0] enc_r(int op, int rd, int rs, int rt);
        return {op[3:0], rd[3:0], rs[3:0], rt[3:0]};
    endfunction
    function automatic logic [15:0] enc_i(int op, int rd, int imm);
        return {op[3:0], rd[3:0], imm[7:0]};
    endfunction

    task automatic put(int a, logic [15:0] w, string t);
        imem[a]   = w;
        tag_of[a] = t;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i]   = 16'h0000;
            tag_of[i] = "R12";
            dmem[i]   = 16'(16'h1000 + i * 7);
        end
    endtask

    task automatic chk(bit ok, string req, int c, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d %s: actual %h expected %h", req, c, what, act, expv);
        end
    endtask

    // Reference model: executes the program in delayed-branch order.
    task automatic run_model();
        logic [15:0] r [16];
        logic [15:0] mm [256];
        int pc, npc, nxt, n, op, rd, rs, rt, a;
        logic [15:0] w, v;
        for (int i = 0; i < 16; i++) r[i] = '0;
        for (int i = 0; i < 256; i++) mm[i] = dmem[i];
        for (int i = 0; i < MAXC; i++) begin
            exp_pc[i] = 0; exp_we[i] = 0; exp_addr[i] = 0;
            exp_wd[i] = '0; exp_halt[i] = 0; exp_tag[i] = "";
        end
        pc = 0; npc = 1; n = 0; last_cyc = 0;
        while (n < MAXC - 3) begin
            w  = imem[pc];
            op = int'(w[15:12]); rd = int'(w[11:8]); rs = int'(w[7:4]); rt = int'(w[3:0]);
            exp_pc[n] = pc;
            nxt = (npc + 1) & 255;
            v = '0;
            case (op)
                1: v = r[rs] + r[rt];
                2: v = r[rs] - r[rt];
                3: v = r[rs] & r[rt];
                4: v = r[rs] | r[rt];
                5: v = r[rd] + {{8{w[7]}}, w[7:0]};
                6: v = mm[(int'(r[rs]) + rt) & 255];
                7: begin
                    a = (int'(r[rs]) + rt) & 255;
                    exp_we[n+2] = 1; exp_addr[n+2] = a; exp_wd[n+2] = r[rd];
                    exp_tag[n+2] = tag_of[pc];
                    mm[a] = r[rd];
                end
                8: if (r[rd] == r[rs]) nxt = (pc + 1 + (rt >= 8 ? rt - 16 : rt)) & 255;
                9: nxt = int'(w[7:0]);
                default: ;
            endcase
            if (op >= 1 && op <= 6 && rd != 0) r[rd] = v;
            if (op == 15) begin
                exp_halt[n+2] = 1;
                exp_pc[n+1] = npc;
                exp_pc[n+2] = nxt;
                last_cyc = n + 2;
                break;
            end
            pc = npc; npc = nxt; n++;
        end
    endtask

    // Hold reset for a few edges, then check the reset state (R10).
    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(imem_addr === 8'd0, "R10", 0, "imem_addr in reset", int'(imem_addr), 0);
        chk(dmem_we === 1'b0,   "R10", 0, "dmem_we in reset", int'(dmem_we), 0);
        chk(dmem_re === 1'b0,   "R10", 0, "dmem_re in reset", int'(dmem_re), 0);
        chk(halt === 1'b0,      "R10", 0, "halt in reset", int'(halt), 0);
    endtask

    // Release reset and compare ports on each cycle, optionally cut short.
    task automatic run_and_compare(int max_cyc);
        int stop;
        run_model();
        stop = (max_cyc < last_cyc) ? max_cyc : last_cyc;
        rst_n = 1'b1;   // at a negedge
        for (int c = 0; c <= stop; c++) begin
            chk(int'(imem_addr) == exp_pc[c], "R1 R8", c, "fetch address",
                int'(imem_addr), exp_pc[c]);
            chk(dmem_we === exp_we[c], "R6", c, "store strobe", int'(dmem_we), int'(exp_we[c]));
            if (exp_we[c]) begin
                chk(int'(dmem_addr) == exp_addr[c], exp_tag[c], c, "store address",
                    int'(dmem_addr), exp_addr[c]);
                chk(dmem_wdata === exp_wd[c], exp_tag[c], c, "store data",
                    int'(dmem_wdata), int'(exp_wd[c]));
            end
            chk(halt === exp_halt[c], "R11", c, "halt", int'(halt), int'(exp_halt[c]));
            if (c < stop) @(negedge clk);
        end
    endtask

    task automatic load_prog1();
        clear_mem();
        put(0,  enc_i(5, 1, 5),        "R4");
        put(1,  enc_i(5, 2, 8'hFD),    "R4");
        put(2,  enc_r(1, 3, 1, 2),     "R3 R7");
        put(3,  enc_r(2, 4, 3, 1),     "R3 R7");
        put(4,  enc_r(3, 5, 4, 1),     "R3 R7");
        put(5,  enc_r(4, 6, 5, 2),     "R3 R7");
        put(6,  enc_i(5, 0, 7),        "R9");
        put(7,  enc_r(1, 7, 0, 1),     "R9");
        put(8,  enc_r(7, 3, 0, 1),     "R3 R2");
        put(9,  enc_r(7, 4, 0, 2),     "R3 SUB");
        put(10, enc_r(7, 5, 0, 3),     "R3 AND");
        put(11, enc_r(7, 6, 0, 4),     "R3 OR");
        put(12, enc_r(7, 7, 0, 5),     "R9 zero");
        put(13, 16'h0ABC,              "R12");
        put(14, 16'hB123,              "R12 R2");
        put(15, enc_r(7, 1, 0, 6),     "R12 NOOP");
        put(16, enc_i(5, 8, 8'h7F),    "R4");
        put(17, enc_r(7, 8, 1, 2),     "R7 store fwd");
        put(18, enc_i(15, 0, 0),       "R11");
    endtask

    task automatic load_prog2();
        clear_mem();
        put(0,  enc_i(5, 1, 8'h10),    "R4");
        put(1,  enc_r(6, 2, 1, 2),     "R5");
        put(2,  16'h0000,              "R12");
        put(3,  enc_r(1, 3, 2, 2),     "R5");
        put(4,  enc_r(7, 3, 1, 0),     "R5 load use");
        put(5,  enc_r(8, 2, 2, 3),     "R8");
        put(6,  enc_i(5, 4, 1),        "R8");
        put(7,  enc_i(5, 4, 8'h40),    "R8");
        put(8,  enc_i(5, 4, 8'h40),    "R8");
        put(9,  enc_r(7, 4, 1, 1),     "R8 delay slot");
        put(10, enc_r(8, 1, 0, 2),     "R8");
        put(11, enc_i(5, 5, 2),        "R8");
        put(12, enc_i(9, 0, 20),       "R8");
        put(13, enc_i(5, 5, 3),        "R8");
        put(14, enc_i(15, 0, 0),       "R8");
        put(20, enc_r(7, 5, 1, 3),     "R8 R10 jump slot");
        put(21, enc_i(5, 6, 3),        "R4");
        put(22, enc_i(5, 6, 8'hFF),    "R4");
        put(23, enc_r(8, 6, 0, 3),     "R7 R8");
        put(24, enc_i(5, 7, 1),        "R8");
        put(25, enc_i(9, 0, 22),       "R8");
        put(26, enc_i(5, 8, 1),        "R8");
        put(27, enc_r(7, 7, 1, 4),     "R8 loop slots");
        put(28, enc_r(7, 8, 1, 5),     "R8 loop jump slot");
        put(29, enc_r(6, 9, 1, 3),     "R5");
        put(30, 16'h0000,              "R12");
        put(31, enc_r(7, 9, 1, 6),     "R5 store then load");
        put(32, enc_i(15, 0, 0),       "R11");
    endtask

    initial begin
        do_reset();
        load_prog1();
        run_and_compare(MAXC);

        do_reset();
        load_prog2();
        run_and_compare(24);          // cut short: R10 reset clears registers
        do_reset();
        load_prog2();
        run_and_compare(MAXC);

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule